// File: doc/BRIEF.md
# Station Address Match Table with Frame Classifier

This block keeps a sixteen-slot table of 48-bit station addresses together with a per-slot enable mask, and uses it to decide whether an arriving frame is meant for this station. A receive path presents the six destination bytes of each frame with a one-cycle strobe. The block answers one cycle later with accept or reject, and marks group-addressed and all-ones frames with their own tags.

The table is filled by a command. The block walks a list of records in memory through a simple 16-bit read port, with one read in flight at a time. Each record names the slot it targets and then supplies the three address words. After the last record, a final word sets the enable mask. The record list can be laid out with one word per 16-bit slot or with one word per 32-bit slot. While the surrounding controller is held in reset, software may inspect any slot through a slot selector.

Top module: `addr_cam_filter`

## Requirements
- R1: After synchronous reset, load_busy, load_done, mem_rd_req and cls_valid are low, cam_enable is zero, and every slot reads back as zero.
- R2: A pulse on load_start while idle raises load_busy and starts a walk at load_ptr. Word k of a record is fetched from the record base plus 2*k when load_wide is 0, or plus 4*k when load_wide is 1. At most one read is outstanding, and mem_rd_req is never high while load_busy is low.
- R3: In each record, word 0 selects the slot through its low 4 bits; its upper bits are ignored. Words 1, 2 and 3 become slot words 0, 1 and 2. A later record that names the same slot overwrites it.
- R4: load_count gives the number of records. The record base advances by 8 bytes (narrow) or 16 bytes (wide) after each record. Once all records have been read, one more word is read at the current base and becomes cam_enable. A count of zero therefore reads only that word.
- R5: A load ends with load_done high for exactly one cycle. load_busy falls in that same cycle.
- R6: If mode_promisc is set and bit 0 of the first destination byte (dest_addr[0]) is clear, the frame is accepted with no tag. A group address is not accepted by this rule.
- R7: Otherwise, if mode_all_mcast is set and dest_addr[0] is set, the frame is accepted with cls_mcast, even when it is all ones.
- R8: Otherwise, if mode_bcast is set and all 48 destination bits are one, the frame is accepted with cls_bcast. cls_mcast and cls_bcast are never high together.
- R9: Otherwise, the frame is accepted with no tag only if some enabled slot equals the destination. Otherwise it is rejected. The first destination byte is dest_addr[7:0]. Slot word 0 holds bytes 1:0 (byte 0 in the low half), word 1 holds bytes 3:2 and word 2 holds bytes 5:4. A slot whose enable bit is clear never matches.
- R10: cls_valid is high exactly in the cycle after a cycle with dest_valid high, and the cls_* results are valid in that cycle.
- R11: While ctrl_in_reset is high, peek_word0..2 show the three words of the slot chosen by peek_sel. While ctrl_in_reset is low, they read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_start | input | 1 | Start a table load (ignored while busy) |
| load_wide | input | 1 | 1: records use 32-bit slots per word; 0: 16-bit slots |
| load_ptr | input | ADDR_W | Byte address of the first record |
| load_count | input | CNT_W | Number of records to read |
| load_busy | output | 1 | A load is in progress |
| load_done | output | 1 | One-cycle pulse when a load completes |
| mem_rd_req | output | 1 | Read request, one cycle per word |
| mem_rd_addr | output | ADDR_W | Byte address of the requested word |
| mem_rd_valid | input | 1 | Read data is valid |
| mem_rd_data | input | 16 | Read data word |
| cam_enable | output | ENTRIES | Per-slot enable mask |
| dest_valid | input | 1 | Destination address strobe |
| dest_addr | input | 48 | Destination, first byte in bits 7:0 |
| mode_promisc | input | 1 | Accept every individual address |
| mode_all_mcast | input | 1 | Accept every group address |
| mode_bcast | input | 1 | Accept the all-ones address |
| cls_valid | output | 1 | Classification result valid |
| cls_accept | output | 1 | Frame accepted |
| cls_mcast | output | 1 | Accepted as group address |
| cls_bcast | output | 1 | Accepted as all-ones address |
| ctrl_in_reset | input | 1 | Controller is in reset; enables slot read-back |
| peek_sel | input | IDX_W | Slot selected for read-back |
| peek_word0 | output | 16 | Slot word 0 (bytes 1:0) |
| peek_word1 | output | 16 | Slot word 1 (bytes 3:2) |
| peek_word2 | output | 16 | Slot word 2 (bytes 5:4) |

## Verification
The bench uses the default parameters: sixteen slots, 32-bit addresses and a 5-bit record count. With these, the sixteen-bit mask word maps one to one onto the slots, and the full slot index range can be reached from record words. Loads are run in narrow mode, in wide mode and with a zero count, so that both stride values and the case with no records are covered. The table of classification vectors is applied against a partly enabled table. It exercises each priority step, including group addresses that are all ones and byte-swapped near-misses of stored addresses.

// File: rtl/addr_cam_pkg.sv
package addr_cam_pkg;

    localparam int WORD_W = 16;
    localparam int MAC_W  = 48;

    typedef logic [MAC_W-1:0]  mac_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ISSUE = 2'd1,
        LD_WAIT  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic promisc;
        logic all_mcast;
        logic bcast_en;
    } rx_mode_t;

    typedef struct packed {
        logic accept;
        logic mcast;
        logic bcast;
    } cls_result_t;

    function automatic logic mac_is_group(input mac_t a);
        return a[0];
    endfunction

    function automatic logic mac_is_all_ones(input mac_t a);
        return &a;
    endfunction

    function automatic cls_result_t classify(input rx_mode_t m, input mac_t a, input logic hit);
        cls_result_t r;
        if (m.promisc && !mac_is_group(a))
            r = '{accept: 1'b1, mcast: 1'b0, bcast: 1'b0};
        else if (m.all_mcast && mac_is_group(a))
            r = '{accept: 1'b1, mcast: 1'b1, bcast: 1'b0};
        else if (m.bcast_en && mac_is_all_ones(a))
            r = '{accept: 1'b1, mcast: 1'b0, bcast: 1'b1};
        else
            r = '{accept: hit, mcast: 1'b0, bcast: 1'b0};
        return r;
    endfunction

endpackage

// File: rtl/cam_list_loader.sv
module cam_list_loader
    import addr_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 5,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               wide,
    input  logic [ADDR_W-1:0]  ptr_init,
    input  logic [CNT_W-1:0]   count_init,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_valid,
    input  word_t              rd_data,
    output logic               busy,
    output logic               done,
    output logic               ent_we,
    output logic [IDX_W-1:0]   ent_idx,
    output logic [1:0]         ent_word,
    output word_t              ent_data,
    output logic               mask_we,
    output logic [ENTRIES-1:0] mask_data
);

    ld_state_e          state_q;
    logic [ADDR_W-1:0]  base_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [1:0]         widx_q;
    logic [IDX_W-1:0]   idx_q;
    logic               wide_q;
    logic [1:0]         shift;
    logic [ADDR_W-1:0]  stride;
    logic               last_word;
    logic               rsp;

    assign shift     = wide_q ? 2'd2 : 2'd1;
    assign stride    = ADDR_W'(4) << shift;
    assign last_word = (cnt_q == '0);
    assign rsp       = (state_q == LD_WAIT) && rd_valid;

    assign rd_req    = (state_q == LD_ISSUE);
    assign rd_addr   = base_q + (ADDR_W'(widx_q) << shift);

    assign ent_we    = rsp && !last_word && (widx_q != 2'd0);
    assign ent_idx   = idx_q;
    assign ent_word  = 2'(widx_q - 2'd1);
    assign ent_data  = rd_data;
    assign mask_we   = rsp && last_word;
    assign mask_data = rd_data[ENTRIES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LD_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            widx_q  <= '0;
            idx_q   <= '0;
            wide_q  <= 1'b0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                LD_IDLE: begin
                    if (start) begin
                        base_q  <= ptr_init;
                        cnt_q   <= count_init;
                        widx_q  <= '0;
                        wide_q  <= wide;
                        busy    <= 1'b1;
                        state_q <= LD_ISSUE;
                    end
                end
                LD_ISSUE: state_q <= LD_WAIT;
                LD_WAIT: begin
                    if (rd_valid) begin
                        if (last_word) begin
                            busy    <= 1'b0;
                            done    <= 1'b1;
                            state_q <= LD_IDLE;
                        end else begin
                            if (widx_q == 2'd0)
                                idx_q <= rd_data[IDX_W-1:0];
                            if (widx_q == 2'd3) begin
                                widx_q <= '0;
                                cnt_q  <= cnt_q - CNT_W'(1);
                                base_q <= base_q + stride;
                            end else begin
                                widx_q <= widx_q + 2'd1;
                            end
                            state_q <= LD_ISSUE;
                        end
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req); // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R5
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

endmodule

// File: rtl/cam_entry_table.sv
module cam_entry_table
    import addr_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ent_we,
    input  logic [IDX_W-1:0]   ent_idx,
    input  logic [1:0]         ent_word,
    input  word_t              ent_data,
    input  logic               mask_we,
    input  logic [ENTRIES-1:0] mask_data,
    input  mac_t               lookup,
    output logic [ENTRIES-1:0] hit_vec,
    output logic [ENTRIES-1:0] mask_q,
    input  logic [IDX_W-1:0]   rd_sel,
    output mac_t               rd_entry
);

    mac_t entry_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[e] <= '0;
            end else if (ent_we && (ent_idx == IDX_W'(e))) begin
                case (ent_word)
                    2'd0:    entry_q[e][15:0]  <= ent_data;
                    2'd1:    entry_q[e][31:16] <= ent_data;
                    default: entry_q[e][47:32] <= ent_data;
                endcase
            end
        end
        assign hit_vec[e] = mask_q[e] && (entry_q[e] == lookup);
    end

    assign rd_entry = entry_q[rd_sel];

    AST_MASK_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$past(mask_we) |-> $stable(mask_q)); // R4

endmodule

// File: rtl/frame_dest_classifier.sv
module frame_dest_classifier
    import addr_cam_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        dest_valid,
    input  mac_t        dest,
    input  rx_mode_t    mode,
    input  logic        hit_any,
    output logic        cls_valid,
    output cls_result_t result
);

    cls_result_t next_res;
    logic        promisc_w;

    assign next_res  = classify(mode, dest, hit_any);
    assign promisc_w = mode.promisc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_valid <= 1'b0;
            result    <= '0;
        end else begin
            cls_valid <= dest_valid;
            if (dest_valid) result <= next_res;
        end
    end

    AST_TAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        cls_valid |-> !(result.mcast && result.bcast)); // R8
    AST_TAG_MEANS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (cls_valid && (result.mcast || result.bcast)) |-> result.accept); // R7
    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        cls_valid |-> $past(dest_valid)); // R10
    AST_PLAIN_ACCEPT_HAS_HIT: assert property (@(posedge clk) disable iff (rst)
        (cls_valid && result.accept && !result.mcast && !result.bcast && !$past(promisc_w))
        |-> $past(hit_any)); // R9

endmodule

// File: rtl/addr_cam_filter.sv
module addr_cam_filter
    import addr_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 5,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_start,
    input  logic               load_wide,
    input  logic [ADDR_W-1:0]  load_ptr,
    input  logic [CNT_W-1:0]   load_count,
    output logic               load_busy,
    output logic               load_done,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [15:0]        mem_rd_data,
    output logic [ENTRIES-1:0] cam_enable,
    input  logic               dest_valid,
    input  logic [47:0]        dest_addr,
    input  logic               mode_promisc,
    input  logic               mode_all_mcast,
    input  logic               mode_bcast,
    output logic               cls_valid,
    output logic               cls_accept,
    output logic               cls_mcast,
    output logic               cls_bcast,
    input  logic               ctrl_in_reset,
    input  logic [IDX_W-1:0]   peek_sel,
    output logic [15:0]        peek_word0,
    output logic [15:0]        peek_word1,
    output logic [15:0]        peek_word2
);

    logic               ent_we;
    logic [IDX_W-1:0]   ent_idx;
    logic [1:0]         ent_word;
    word_t              ent_data;
    logic               mask_we;
    logic [ENTRIES-1:0] mask_data;
    logic [ENTRIES-1:0] hit_vec;
    mac_t               rd_entry;
    rx_mode_t           mode;
    cls_result_t        result;

    assign mode = '{promisc: mode_promisc, all_mcast: mode_all_mcast, bcast_en: mode_bcast};

    cam_list_loader #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) loader_i (
        .clk        (clk),
        .rst        (rst),
        .start      (load_start),
        .wide       (load_wide),
        .ptr_init   (load_ptr),
        .count_init (load_count),
        .rd_req     (mem_rd_req),
        .rd_addr    (mem_rd_addr),
        .rd_valid   (mem_rd_valid),
        .rd_data    (mem_rd_data),
        .busy       (load_busy),
        .done       (load_done),
        .ent_we     (ent_we),
        .ent_idx    (ent_idx),
        .ent_word   (ent_word),
        .ent_data   (ent_data),
        .mask_we    (mask_we),
        .mask_data  (mask_data)
    );

    cam_entry_table #(.ENTRIES(ENTRIES)) table_i (
        .clk       (clk),
        .rst       (rst),
        .ent_we    (ent_we),
        .ent_idx   (ent_idx),
        .ent_word  (ent_word),
        .ent_data  (ent_data),
        .mask_we   (mask_we),
        .mask_data (mask_data),
        .lookup    (dest_addr),
        .hit_vec   (hit_vec),
        .mask_q    (cam_enable),
        .rd_sel    (peek_sel),
        .rd_entry  (rd_entry)
    );

    frame_dest_classifier classifier_i (
        .clk        (clk),
        .rst        (rst),
        .dest_valid (dest_valid),
        .dest       (dest_addr),
        .mode       (mode),
        .hit_any    (|hit_vec),
        .cls_valid  (cls_valid),
        .result     (result)
    );

    assign cls_accept = result.accept;
    assign cls_mcast  = result.mcast;
    assign cls_bcast  = result.bcast;

    assign peek_word0 = ctrl_in_reset ? rd_entry[15:0]  : 16'h0000;
    assign peek_word1 = ctrl_in_reset ? rd_entry[31:16] : 16'h0000;
    assign peek_word2 = ctrl_in_reset ? rd_entry[47:32] : 16'h0000;

    AST_NO_LOAD_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ent_we || mask_we) |-> load_busy); // R3

endmodule

// File: tb/addr_cam_filter_tb.sv
`timescale 1ns/1ps
module addr_cam_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        load_start, load_wide;
    logic [31:0] load_ptr;
    logic [4:0]  load_count;
    logic        load_busy, load_done;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [15:0] mem_rd_data;
    logic [15:0] cam_enable;
    logic        dest_valid;
    logic [47:0] dest_addr;
    logic        mode_promisc, mode_all_mcast, mode_bcast;
    logic        cls_valid, cls_accept, cls_mcast, cls_bcast;
    logic        ctrl_in_reset;
    logic [3:0]  peek_sel;
    logic [15:0] peek_word0, peek_word1, peek_word2;

    int checks = 0;
    int fails  = 0;

    logic [15:0] mem [256];
    logic [31:0] rlog [64];
    int          rn;
    logic        pend;
    logic [31:0] paddr;

    always #4 clk = ~clk;

    addr_cam_filter dut_i (
        .clk(clk), .rst(rst),
        .load_start(load_start), .load_wide(load_wide), .load_ptr(load_ptr), .load_count(load_count),
        .load_busy(load_busy), .load_done(load_done),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .cam_enable(cam_enable),
        .dest_valid(dest_valid), .dest_addr(dest_addr),
        .mode_promisc(mode_promisc), .mode_all_mcast(mode_all_mcast), .mode_bcast(mode_bcast),
        .cls_valid(cls_valid), .cls_accept(cls_accept), .cls_mcast(cls_mcast), .cls_bcast(cls_bcast),
        .ctrl_in_reset(ctrl_in_reset), .peek_sel(peek_sel),
        .peek_word0(peek_word0), .peek_word1(peek_word1), .peek_word2(peek_word2)
    );

    // Addresses used below; first byte in bits 7:0
    localparam logic [47:0] MAC_A = 48'h1100_0000_0002;
    localparam logic [47:0] MAC_B = 48'h5544_3322_1104;
    localparam logic [47:0] MAC_C = 48'hEEDD_CCBB_AA06;
    localparam logic [47:0] MAC_U = 48'h0000_0000_0010;
    localparam logic [47:0] MAC_G = 48'h0000_0000_0001;
    localparam logic [47:0] MAC_F = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MAC_S = 48'h1100_0000_0200;

    // {promisc, all_mcast, bcast, dest[47:0], accept, mcast, bcast}
    localparam int NV = 12;
    localparam logic [53:0] VECS [NV] = '{
        {3'b000, MAC_A, 3'b100},
        {3'b000, MAC_B, 3'b100},
        {3'b000, MAC_C, 3'b000},
        {3'b000, MAC_U, 3'b000},
        {3'b001, MAC_F, 3'b101},
        {3'b000, MAC_F, 3'b000},
        {3'b011, MAC_F, 3'b110},
        {3'b010, MAC_G, 3'b110},
        {3'b100, MAC_U, 3'b100},
        {3'b100, MAC_G, 3'b000},
        {3'b111, MAC_G, 3'b110},
        {3'b000, MAC_S, 3'b000}
    };

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory responder: one word returned one cycle after each request
    initial begin
        pend = 1'b0;
        paddr = '0;
        rn = 0;
        mem_rd_valid = 1'b0;
        mem_rd_data = '0;
        forever begin
            @(negedge clk);
            mem_rd_valid = 1'b0;
            if (pend) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem[paddr[8:1]];
                pend = 1'b0;
            end
            if (mem_rd_req) begin
                pend  = 1'b1;
                paddr = mem_rd_addr;
                if (rn < 64) rlog[rn] = mem_rd_addr;
                rn++;
            end
        end
    end

    task automatic put(input int byte_addr, input logic [15:0] v);
        mem[8'(byte_addr >> 1)] = v;
    endtask

    task automatic run_load(input logic wide, input logic [31:0] ptr, input logic [4:0] cnt);
        int done_seen = 0;
        int busy_at_done = 0;
        @(negedge clk);
        rn = 0;
        load_wide = wide; load_ptr = ptr; load_count = cnt; load_start = 1'b1;
        @(negedge clk);
        load_start = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (load_done) begin
                done_seen++;
                if (load_busy) busy_at_done++;
            end
            if (!load_busy && done_seen > 0) break;
        end
        @(negedge clk);
        if (load_done) done_seen++;
        check(done_seen == 1, "R5 done pulse count", 64'(done_seen), 64'd1);
        check(busy_at_done == 0, "R5 busy low with done", 64'(busy_at_done), 64'd0);
    endtask

    task automatic classify_one(input logic p, input logic m, input logic b, input logic [47:0] d,
                                input logic [2:0] exp, input string req);
        @(negedge clk);
        mode_promisc = p; mode_all_mcast = m; mode_bcast = b;
        dest_addr = d; dest_valid = 1'b1;
        @(negedge clk);
        dest_valid = 1'b0;
        check(cls_valid == 1'b1, "R10 valid after strobe", 64'(cls_valid), 64'd1);
        check({cls_accept, cls_mcast, cls_bcast} == exp, req,
              64'({cls_accept, cls_mcast, cls_bcast}), 64'(exp));
        @(negedge clk);
        check(cls_valid == 1'b0, "R10 valid single cycle", 64'(cls_valid), 64'd0);
    endtask

    task automatic peek(input logic [3:0] sel, input logic [47:0] exp, input string req);
        @(negedge clk);
        peek_sel = sel;
        #1;
        check({peek_word2, peek_word1, peek_word0} == exp, req,
              64'({peek_word2, peek_word1, peek_word0}), 64'(exp));
    endtask

    initial begin
        rst = 1'b1;
        load_start = 1'b0; load_wide = 1'b0; load_ptr = '0; load_count = '0;
        dest_valid = 1'b0; dest_addr = '0;
        mode_promisc = 1'b0; mode_all_mcast = 1'b0; mode_bcast = 1'b0;
        ctrl_in_reset = 1'b1; peek_sel = '0;
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

        // Narrow list at 0x40: three records, then enable mask
        put(32'h40, 16'h00F3); put(32'h42, 16'h0002); put(32'h44, 16'h0000); put(32'h46, 16'h1100);
        put(32'h48, 16'h0005); put(32'h4A, 16'h1104); put(32'h4C, 16'h3322); put(32'h4E, 16'h5544);
        put(32'h50, 16'h0009); put(32'h52, 16'hAA06); put(32'h54, 16'hCCBB); put(32'h56, 16'hEEDD);
        put(32'h58, 16'h0028);
        // Wide list at 0x80: one record rewriting slot 5, then mask
        put(32'h80, 16'hA7C5); put(32'h84, 16'hBEEF); put(32'h88, 16'h0123); put(32'h8C, 16'h4567);
        put(32'h90, 16'hFFFF);
        // Zero-record list at 0xA0
        put(32'hA0, 16'h0008);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(!load_busy && !load_done && !mem_rd_req && !cls_valid, "R1 idle outputs",
              64'({load_busy, load_done, mem_rd_req, cls_valid}), 64'd0);
        check(cam_enable == 16'h0, "R1 mask cleared", 64'(cam_enable), 64'd0);
        peek(4'd0, 48'h0, "R1 slot cleared");

        // R2/R3/R4: narrow load
        run_load(1'b0, 32'h40, 5'd3);
        check(rn == 13, "R4 narrow read count", 64'(rn), 64'd13);
        for (int k = 0; k < 13; k++)
            check(rlog[k] == 32'h40 + 32'(2 * k), "R2 narrow address", 64'(rlog[k]), 64'(32'h40 + 2 * k));
        check(cam_enable == 16'h0028, "R4 mask loaded", 64'(cam_enable), 64'h28);
        peek(4'd3, MAC_A, "R3 slot 3 from index with upper bits");
        peek(4'd5, MAC_B, "R3 slot 5 contents");
        peek(4'd9, MAC_C, "R3 slot 9 contents");

        // R11: read-back blocked outside reset
        ctrl_in_reset = 1'b0;
        peek(4'd5, 48'h0, "R11 read-back zero outside reset");
        ctrl_in_reset = 1'b1;
        peek(4'd5, MAC_B, "R11 read-back in reset");

        // Vector table: R6 R7 R8 R9
        for (int v = 0; v < NV; v++)
            classify_one(VECS[v][53], VECS[v][52], VECS[v][51], VECS[v][50:3], VECS[v][2:0],
                         "R6 R7 R8 R9 vector result");

        // Wide load: R2 stride, R3 overwrite
        run_load(1'b1, 32'h80, 5'd1);
        check(rn == 5, "R4 wide read count", 64'(rn), 64'd5);
        for (int k = 0; k < 5; k++)
            check(rlog[k] == 32'h80 + 32'(4 * k), "R2 wide address", 64'(rlog[k]), 64'(32'h80 + 4 * k));
        peek(4'd5, 48'h4567_0123_BEEF, "R3 slot 5 overwritten");
        check(cam_enable == 16'hFFFF, "R4 wide mask", 64'(cam_enable), 64'hFFFF);
        classify_one(1'b0, 1'b0, 1'b0, 48'h4567_0123_BEEF, 3'b100, "R9 match after overwrite");
        classify_one(1'b0, 1'b0, 1'b0, MAC_B, 3'b000, "R3 old contents gone");
        classify_one(1'b0, 1'b0, 1'b0, MAC_C, 3'b100, "R9 slot now enabled");

        // Zero-count load: only the mask word is read
        run_load(1'b0, 32'hA0, 5'd0);
        check(rn == 1, "R4 zero count reads one word", 64'(rn), 64'd1);
        check(rlog[0] == 32'hA0, "R4 mask address", 64'(rlog[0]), 64'hA0);
        check(cam_enable == 16'h0008, "R4 mask after zero count", 64'(cam_enable), 64'h8);
        classify_one(1'b0, 1'b0, 1'b0, MAC_C, 3'b000, "R9 disabled slot rejects");
        classify_one(1'b0, 1'b0, 1'b0, MAC_A, 3'b100, "R9 enabled slot accepts");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R1-timeout actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule